// File: doc/BRIEF.md
# Multicycle 8-bit Accumulator Processor Core

This block is a small processor core built around one 8-bit accumulator, one 8-bit auxiliary register and a single zero flag. It reaches a 64K-byte address space through one byte-wide memory port. A state machine steps through fetch, decode and execute. Each memory read takes two cycles: in the first the core presents the address, and in the second it captures the returned byte. Instructions that use memory or change control flow carry a two-byte address after the opcode. All other instructions are one byte long.

The core runs from address zero after a synchronous reset and keeps running until it decodes the stop opcode. It then raises a status output and stays idle until the next reset. Program and data both sit in an external memory whose reads return data one clock after the address.

Top module: `acc8_core`

## Requirements
- R1: While `rst` is high at a clock edge, the core clears the program counter, accumulator, auxiliary register and zero flag. During reset and afterwards, `halted` is low and `mem_we` is low, and `mem_addr` reads 0, which is also the first fetch address.
- R2: Every instruction starts with two cycles that present the program counter on `mem_addr`. The opcode is captured at the end of the second cycle and a decode cycle follows. A one-byte instruction therefore takes 3 cycles, and the next fetch uses the following address.
- R3: Opcodes 0x01, 0x02, 0x05, 0x06 and 0x07 are three bytes long. The opcode is followed by an address, low byte first. The core fetches the low byte in cycles 3–4 (address PC+1) and the high byte in cycles 5–6 (address PC+2) of the instruction. Every other opcode is one byte long.
- R4: Opcode 0x01 (load) takes 9 cycles. In cycles 7 and 8 it presents the operand address, and it copies the returned byte into the accumulator. The zero flag does not change.
- R5: Opcode 0x02 (store) takes 8 cycles. `mem_we` is high only in cycle 7, with `mem_addr` equal to the operand and `mem_wdata` equal to the accumulator. The zero flag does not change.
- R6: Opcode 0x03 copies the accumulator into the auxiliary register, and opcode 0x04 copies the auxiliary register into the accumulator. Neither changes the zero flag.
- R7: Opcode 0x08 adds the auxiliary register to the accumulator, 0x09 subtracts it from the accumulator, and 0x0A increments the accumulator. All results wrap modulo 256. Each sets the zero flag exactly when its 8-bit result is zero.
- R8: Opcodes 0x0C, 0x0D, 0x0E and 0x0F write to the accumulator the bitwise AND, OR and XOR with the auxiliary register, and the accumulator's complement. Each sets the zero flag exactly when its result is zero.
- R9: Opcode 0x0B clears the accumulator and sets the zero flag.
- R10: Opcode 0x05 takes 7 cycles. The next fetch is at the operand address.
- R11: Opcodes 0x06 (branch if zero flag set) and 0x07 (branch if zero flag clear) take 7 cycles. If the branch is taken, the next fetch is at the operand. If not, the next fetch is at the opcode address plus 3. Neither changes the zero flag.
- R12: Opcode 0x00 and every opcode not listed here take 3 cycles, advance the program counter by one, and leave all registers and the zero flag unchanged.
- R13: Opcode 0xFF raises `halted` after its 3-cycle fetch and decode. From then until reset, `halted` stays high and `mem_we` stays low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| mem_addr | output | 16 | Memory address for reads and writes |
| mem_wdata | output | 8 | Byte to write (the accumulator) |
| mem_we | output | 1 | Write strobe, one cycle per store |
| mem_rdata | input | 8 | Byte read, valid one cycle after its address |
| halted | output | 1 | High once the stop opcode has executed |

## Verification
The cycle that captures the high address byte both advances the program counter and, for a taken branch, loads it with the operand, so the two updates fall on the same clock edge. The bench provokes this with both branch opcodes in their taken and not-taken cases, with an unconditional jump, and with a counting loop whose backward branch is taken several times before it falls through. The outcome is judged by the address presented in the first cycle of the next instruction, which must be either the operand or the opcode address plus 3. A second collision, reset arriving while the core is halted, is judged by the reset-state outputs and by the register contents that the next program stores.

// File: rtl/acc8_pkg.sv
package acc8_pkg;

  localparam int DATA_W = 8;
  localparam int ADDR_W = 16;

  typedef logic [DATA_W-1:0] byte_t;
  typedef logic [ADDR_W-1:0] addr_t;

  typedef enum logic [7:0] {
    OP_NOP   = 8'h00,
    OP_LOAD  = 8'h01,
    OP_STORE = 8'h02,
    OP_A2R   = 8'h03,
    OP_R2A   = 8'h04,
    OP_JMP   = 8'h05,
    OP_JZ    = 8'h06,
    OP_JNZ   = 8'h07,
    OP_ADD   = 8'h08,
    OP_SUB   = 8'h09,
    OP_INC   = 8'h0A,
    OP_CLR   = 8'h0B,
    OP_AND   = 8'h0C,
    OP_OR    = 8'h0D,
    OP_XOR   = 8'h0E,
    OP_INV   = 8'h0F,
    OP_STOP  = 8'hFF
  } op_e;

  typedef enum logic [3:0] {
    S_FADR, S_FCAP, S_DEC,
    S_LOADR, S_LOCAP, S_HIADR, S_HICAP,
    S_RDADR, S_RDCAP, S_WR, S_STOP
  } state_e;

  // opcodes followed by a two-byte address
  function automatic logic has_operand(byte_t op);
    return (op == OP_LOAD) || (op == OP_STORE) || (op == OP_JMP) ||
           (op == OP_JZ) || (op == OP_JNZ);
  endfunction

  // opcodes that write the accumulator and refresh the zero flag
  function automatic logic is_arith(byte_t op);
    return (op >= OP_ADD) && (op <= OP_INV);
  endfunction

  function automatic byte_t alu_result(byte_t op, byte_t a, byte_t r);
    byte_t y;
    case (op)
      OP_ADD:  y = a + r;
      OP_SUB:  y = a - r;
      OP_INC:  y = a + byte_t'(1);
      OP_AND:  y = a & r;
      OP_OR:   y = a | r;
      OP_XOR:  y = a ^ r;
      OP_INV:  y = ~a;
      OP_R2A:  y = r;
      default: y = '0;
    endcase
    return y;
  endfunction

  function automatic logic branch_taken(byte_t op, logic zf);
    return (op == OP_JMP) || ((op == OP_JZ) && zf) || ((op == OP_JNZ) && !zf);
  endfunction

endpackage

// File: rtl/acc8_alu.sv
module acc8_alu
  import acc8_pkg::*;
(
  input  logic [DATA_W-1:0] op,
  input  logic [DATA_W-1:0] acc,
  input  logic [DATA_W-1:0] aux,
  output logic [DATA_W-1:0] result,
  output logic              acc_wr,
  output logic              zf_upd
);

  always_comb begin
    result = alu_result(op, acc, aux);
    zf_upd = is_arith(op);
    acc_wr = is_arith(op) || (op == OP_R2A);
  end

endmodule

// File: rtl/acc8_seq.sv
module acc8_seq
  import acc8_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] op,
  output state_e            st
);

  state_e st_nx;

  always_comb begin
    st_nx = st;
    case (st)
      S_FADR:  st_nx = S_FCAP;
      S_FCAP:  st_nx = S_DEC;
      S_DEC: begin
        if (op == OP_STOP)        st_nx = S_STOP;
        else if (has_operand(op)) st_nx = S_LOADR;
        else                      st_nx = S_FADR;
      end
      S_LOADR: st_nx = S_LOCAP;
      S_LOCAP: st_nx = S_HIADR;
      S_HIADR: st_nx = S_HICAP;
      S_HICAP: begin
        if (op == OP_LOAD)       st_nx = S_RDADR;
        else if (op == OP_STORE) st_nx = S_WR;
        else                     st_nx = S_FADR;
      end
      S_RDADR: st_nx = S_RDCAP;
      S_RDCAP: st_nx = S_FADR;
      S_WR:    st_nx = S_FADR;
      S_STOP:  st_nx = S_STOP;
      default: st_nx = S_FADR;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) st <= S_FADR;
    else     st <= st_nx;
  end

endmodule

// File: rtl/acc8_core.sv
module acc8_core
  import acc8_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  output logic              mem_we,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              halted
);

  state_e st;
  addr_t  pc, ar;
  byte_t  ac, rx, ir, tr;
  logic   zf;

  byte_t  alu_y;
  logic   alu_acc_wr, alu_zf_upd;

  // named internal events
  logic   ev_fetch, ev_exec, ev_lo, ev_hi, ev_jump, ev_load;
  addr_t  opnd;

  acc8_seq u_seq (
    .clk (clk),
    .rst (rst),
    .op  (ir),
    .st  (st)
  );

  acc8_alu u_alu (
    .op     (ir),
    .acc    (ac),
    .aux    (rx),
    .result (alu_y),
    .acc_wr (alu_acc_wr),
    .zf_upd (alu_zf_upd)
  );

  always_comb begin
    ev_fetch = (st == S_FCAP);
    ev_exec  = (st == S_DEC);
    ev_lo    = (st == S_LOCAP);
    ev_hi    = (st == S_HICAP);
    ev_load  = (st == S_RDCAP);
    opnd     = {mem_rdata, tr};
    ev_jump  = ev_hi && branch_taken(ir, zf);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pc <= '0;
      ar <= '0;
      ac <= '0;
      rx <= '0;
      ir <= '0;
      tr <= '0;
      zf <= 1'b0;
    end else begin
      if (ev_fetch) begin
        ir <= mem_rdata;
        pc <= pc + addr_t'(1);
      end
      if (ev_lo) begin
        tr <= mem_rdata;
        pc <= pc + addr_t'(1);
      end
      if (ev_hi) begin
        ar <= opnd;
        pc <= ev_jump ? opnd : pc + addr_t'(1);
      end
      if (ev_load) ac <= mem_rdata;
      if (ev_exec) begin
        if (alu_acc_wr)   ac <= alu_y;
        if (alu_zf_upd)   zf <= (alu_y == '0);
        if (ir == OP_A2R) rx <= ac;
      end
    end
  end

  always_comb begin
    mem_addr  = (st == S_RDADR || st == S_RDCAP || st == S_WR) ? ar : pc;
    mem_wdata = ac;
    mem_we    = (st == S_WR);
    halted    = (st == S_STOP);
  end

endmodule

// File: rtl/acc8_chk.sv
module acc8_chk
  import acc8_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic              halted,
  input logic              mem_we,
  input logic [ADDR_W-1:0] pc,
  input logic [ADDR_W-1:0] ar,
  input logic [DATA_W-1:0] ac,
  input logic [DATA_W-1:0] ir,
  input logic              zf,
  input logic              ev_fetch,
  input logic              ev_exec,
  input logic              ev_jump,
  input logic              zf_upd
);

  p_quiet_when_stopped_r13: assert property (@(posedge clk) disable iff (rst)
    halted |-> !mem_we);

  p_stop_is_sticky_r13: assert property (@(posedge clk) disable iff (rst)
    halted |=> halted);

  p_stop_from_opcode_r13: assert property (@(posedge clk) disable iff (rst)
    $rose(halted) |-> (ir == 8'hFF));

  p_fetch_advances_pc_r2: assert property (@(posedge clk) disable iff (rst)
    ev_fetch |=> (pc == $past(pc) + 16'd1));

  p_zero_follows_acc_r7: assert property (@(posedge clk) disable iff (rst)
    (ev_exec && zf_upd) |=> (zf == (ac == 8'h00)));

  p_zero_kept_on_moves_r6: assert property (@(posedge clk) disable iff (rst)
    (ev_exec && !zf_upd) |=> $stable(zf));

  p_jump_lands_on_operand_r10: assert property (@(posedge clk) disable iff (rst)
    ev_jump |=> (pc == ar));

  p_single_write_pulse_r5: assert property (@(posedge clk) disable iff (rst)
    mem_we |=> !mem_we);

endmodule

bind acc8_core acc8_chk u_chk (
  .clk      (clk),
  .rst      (rst),
  .halted   (halted),
  .mem_we   (mem_we),
  .pc       (pc),
  .ar       (ar),
  .ac       (ac),
  .ir       (ir),
  .zf       (zf),
  .ev_fetch (ev_fetch),
  .ev_exec  (ev_exec),
  .ev_jump  (ev_jump),
  .zf_upd   (alu_zf_upd)
);

// File: tb/test_acc8_core.sv
`timescale 1ns/1ps
module test_acc8_core;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] mem_addr;
  logic [7:0]  mem_wdata;
  logic        mem_we;
  logic [7:0]  mem_rdata;
  logic        halted;

  int checks = 0;
  int fails  = 0;
  int p      = 0;

  logic [7:0] img [0:4095];
  logic [7:0] mem [0:4095];
  int         shadow [0:4095];

  always #2 clk = ~clk;

  acc8_core i_acc8_core (
    .clk       (clk),
    .rst       (rst),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .mem_we    (mem_we),
    .mem_rdata (mem_rdata),
    .halted    (halted)
  );

  // byte memory: image copied in while reset is held, reads one cycle late
  always @(posedge clk) begin
    if (rst) mem <= img;
    else if (mem_we) mem[mem_addr[11:0]] <= mem_wdata;
    mem_rdata <= mem[mem_addr[11:0]];
  end

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic step(input string req, input bit chk_addr, input int exp_addr,
                      input bit exp_we, input int exp_wd, input bit exp_halt);
    check(halted === exp_halt, req, "halted", int'(halted), int'(exp_halt));
    check(mem_we === exp_we, req, "mem_we", int'(mem_we), int'(exp_we));
    if (chk_addr)
      check(mem_addr === exp_addr[15:0], req, "mem_addr", int'(mem_addr), exp_addr & 16'hFFFF);
    if (exp_we)
      check(mem_wdata === exp_wd[7:0], req, "mem_wdata", int'(mem_wdata), exp_wd & 8'hFF);
    @(negedge clk);
  endtask

  function automatic string req_of(int op);
    case (op)
      1:            return "R4";
      2:            return "R5";
      3, 4:         return "R6";
      5:            return "R10";
      6, 7:         return "R11";
      8, 9, 10:     return "R7";
      11:           return "R9";
      12, 13, 14, 15: return "R8";
      255:          return "R13";
      default:      return "R12";
    endcase
  endfunction

  task automatic e1(input int b);
    img[p] = b[7:0];
    p++;
  endtask

  task automatic e3(input int op, input int a);
    e1(op);
    e1(a & 255);
    e1((a >> 8) & 255);
  endtask

  task automatic patch(input int at, input int a);
    img[at]   = a[7:0];
    img[at+1] = a[15:8];
  endtask

  task automatic clear_image();
    for (int i = 0; i < 4096; i++) img[i] = 8'h00;
    p = 0;
  endtask

  // behavioural reference: executes instruction by instruction, compares every cycle
  task automatic run_program(input int max_insn);
    int pc = 0, ac = 0, rv = 0, zf = 0;
    int op, tgt, n, npc;
    bit lng, done = 0;
    for (int i = 0; i < 4096; i++) shadow[i] = int'(img[i]);
    rst = 1'b1;
    repeat (3) @(negedge clk);
    check(halted === 1'b0, "R1", "halted in reset", int'(halted), 0);
    check(mem_we === 1'b0, "R1", "mem_we in reset", int'(mem_we), 0);
    check(mem_addr === 16'h0000, "R1", "mem_addr in reset", int'(mem_addr), 0);
    rst = 1'b0;
    for (int s = 0; s < max_insn && !done; s++) begin
      op  = shadow[pc & 12'hFFF];
      lng = (op == 1) || (op == 2) || (op == 5) || (op == 6) || (op == 7);
      tgt = shadow[(pc + 1) & 12'hFFF] | (shadow[(pc + 2) & 12'hFFF] << 8);
      n   = (op == 1) ? 9 : (op == 2) ? 8 : lng ? 7 : 3;
      for (int k = 0; k < n; k++) begin
        if (k == 0)                 step("R2", 1, pc, 0, 0, 0);
        else if (lng && k == 3)     step("R3", 1, pc + 1, 0, 0, 0);
        else if (lng && k == 5)     step("R3", 1, pc + 2, 0, 0, 0);
        else if (k == 7)            step(req_of(op), 1, tgt, op == 2, ac, 0);
        else                        step(req_of(op), 0, 0, 0, 0, 0);
      end
      npc = pc + (lng ? 3 : 1);
      case (op)
        1:  ac = shadow[tgt & 12'hFFF];
        2:  shadow[tgt & 12'hFFF] = ac;
        3:  rv = ac;
        4:  ac = rv;
        5:  npc = tgt;
        6:  if (zf != 0) npc = tgt;
        7:  if (zf == 0) npc = tgt;
        8:  begin ac = (ac + rv) & 255;   zf = (ac == 0); end
        9:  begin ac = (ac - rv) & 255;   zf = (ac == 0); end
        10: begin ac = (ac + 1) & 255;    zf = (ac == 0); end
        11: begin ac = 0;                 zf = 1;         end
        12: begin ac = ac & rv;           zf = (ac == 0); end
        13: begin ac = ac | rv;           zf = (ac == 0); end
        14: begin ac = ac ^ rv;           zf = (ac == 0); end
        15: begin ac = (~ac) & 255;       zf = (ac == 0); end
        255: done = 1;
        default: ;
      endcase
      pc = npc & 16'hFFFF;
    end
    if (done) begin
      for (int k = 0; k < 6; k++) step("R13", 0, 0, 0, 0, 1);
    end else begin
      check(1'b0, "R13", "stop opcode reached", 0, 1);
    end
  endtask

  int fx;

  initial begin
    // program 1: arithmetic, logic, moves, branches, unknown opcodes
    clear_image();
    img[12'h800] = 8'hFF; img[12'h801] = 8'h5A; img[12'h802] = 8'h3C;
    img[12'hF00] = 8'hFF;
    e1(8'h0B);              // clear
    e3(8'h07, 16'h0F00);    // not taken after clear
    e1(8'h0A);              // inc -> 1
    e1(8'h03);              // r = 1
    e3(8'h01, 16'h0800);    // acc = FF, flag kept
    e1(8'h08);              // FF + 1 wraps to 0
    e3(8'h06, 0); fx = p - 2;
    e1(8'hFF);              // skipped
    patch(fx, p);
    e3(8'h02, 16'h0900);
    e3(8'h01, 16'h0801);
    e1(8'h03);
    e3(8'h01, 16'h0802);
    e1(8'h09);              // 3C - 5A wraps
    e3(8'h02, 16'h0901);
    e1(8'h0C); e3(8'h02, 16'h0902);
    e1(8'h0D); e1(8'h0E);   // xor to zero
    e3(8'h07, 16'h0F00);    // not taken
    e1(8'h0F); e3(8'h02, 16'h0903);
    e3(8'h06, 16'h0F00);    // not taken, flag clear
    e1(8'h0A);              // FF + 1 -> 0
    e1(8'h04);              // move keeps flag set
    e3(8'h06, 0); fx = p - 2;
    e1(8'hFF);
    patch(fx, p);
    e1(8'h42); e1(8'h10);   // unknown opcodes
    e3(8'h02, 16'h0904);
    e3(8'h05, 0); fx = p - 2;
    e1(8'hFF); e1(8'hFF);
    patch(fx, p);
    e1(8'h00);
    e3(8'h02, 16'h0905);
    e1(8'hFF);
    run_program(200);

    // program 2: reset while stopped, counting loop with backward branch
    rst = 1'b1;
    clear_image();
    img[12'h800] = 8'hFB;
    img[12'hF00] = 8'hFF;
    e3(8'h02, 16'h0B00);    // accumulator cleared by reset (R1)
    e1(8'h04);
    e3(8'h02, 16'h0B01);    // aux register cleared by reset (R1)
    e3(8'h06, 16'h0F00);    // flag cleared by reset: not taken (R1)
    e3(8'h01, 16'h0800);
    fx = p;
    e1(8'h0A);
    e3(8'h02, 16'h0A00);
    e3(8'h07, fx);
    e3(8'h01, 16'h0A00);
    e3(8'h02, 16'h0A01);
    e1(8'hFF);
    run_program(200);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #400000;
    checks++;
    fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule